// File: doc/BRIEF.md
# Card Host Command Launch and Card-Clock Update Front End

This block sits at the software-facing end of a memory-card host controller. Software first writes a command argument and then a command word. The command word holds an opcode, a set of flag bits and a start bit. The block latches the command and offers it to the command serialiser through a valid/ready handshake. The start bit reads back as set for as long as the command waits, and it clears once the serialiser has taken the command. A command that asks to wait for the previous transfer is held back while the data path reports busy.

The card clock is set through a clock control register. That register holds a divider, an enable and an idle-gating bit. Writing it has no effect on the running clock. The settings take effect only when software issues a clock-update-only command. That command goes through the same start-bit handshake but never reaches the card line. The usual sequence is:

1. Disable the clock and issue a clock update.
2. Change the divider.
3. Enable the clock and issue a clock update again.

A bus width register selects how many data lanes are in use. For every launched command the block also reports which completion events software should wait for.

Top module: `card_cmd_frontend`

## Requirements
- R1: After reset:
  - the start bit reads 0 and `cmd_valid` is 0;
  - the card clock is low and the active clock enable is 0;
  - the command register reads 0;
  - `bus_lanes` is 4'b0001.
- R2: A write at address 1 with bit 31 set launches a command.
  - From the next cycle the start bit reads back as 1 and `cmd_valid` is high.
  - `cmd_index` carries bits 5:0 of the write and `cmd_flags` carries bits 15:6 of the write.
  - `cmd_arg` carries the value held at address 0 at the time of the launch.
- R3: Once `cmd_valid` is high, it and the command outputs stay unchanged until `cmd_ready` is high. In the cycle after `cmd_valid` and `cmd_ready` are both high, the start bit reads 0 and `cmd_valid` is low.
- R4: A write at address 1 while the start bit is set is ignored, and the command already held is unchanged.
- R5: A command with bit 13 (wait-previous) set is not offered, and a clock update with bit 13 set is not applied, while `data_busy` is high. In that time the start bit keeps reading 1.
- R6: A launched command with bit 21 (clock update only) set never raises `cmd_valid`. When it is accepted:
  - the divider (bits 7:0), enable (bit 16) and gating (bit 17) held at address 2 become the active clock settings;
  - the start bit clears.
- R7: Writing the clock control register at address 2 alone does not change the active clock settings or the card clock.
- R8: With the active enable set, `card_clk` has a period of 2×(divider+1) input clock cycles. With the active enable clear, `card_clk` stays low.
- R9: With the active gating bit set, `card_clk` is held low while no command is pending and `data_busy` is low. It runs again when `data_busy` rises.
- R10: For an offered command, `evt_wait_mask` is built as follows:
  - bit 0 (command done) is always set;
  - bit 1 (data over) is set when the data flag (bit 9) is set;
  - bit 2 (auto-stop done) is set only when both the data flag and the auto-stop flag (bit 12) are set.
- R11: Address 3 holds the bus width code: 0 gives `bus_lanes` 4'b0001, 1 gives 4'b0100 and 2 gives 4'b1000. A write of code 3 is ignored.
- R12: A write at address 1 with bit 31 clear stores the opcode and flags, which read back, but launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address (0 arg, 1 command, 2 clock control, 3 bus width) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| data_busy | input | 1 | Data path is not idle |
| cmd_ready | input | 1 | Serialiser accepts the offered command |
| cmd_valid | output | 1 | Command offered to the serialiser |
| cmd_index | output | 6 | Offered opcode |
| cmd_flags | output | 10 | Offered flags (command bits 15:6) |
| cmd_arg | output | 32 | Offered argument |
| evt_wait_mask | output | 3 | Events to wait for: {auto-stop, data over, command done} |
| card_clk | output | 1 | Divided card clock |
| clk_act_div | output | 8 | Active divider |
| clk_act_en | output | 1 | Active card clock enable |
| bus_lanes | output | 4 | One-hot data lane count (bit 0 = 1, bit 2 = 4, bit 3 = 8) |

## Verification
The bound checker watches these rules on every cycle:
- the valid hold and the acceptance of the start bit;
- the wait-previous gate against `data_busy`;
- that a clock update and a command offer never coincide;
- that the active clock settings move only on an applied update;
- that the card clock is low when it is disabled or idle-gated;
- that the lane output stays legal.

Some behaviour only the directed scenarios can show, by measuring `card_clk` periods and following reads:
- the actual divider period;
- the full disable, re-divide, re-enable sequence;
- the values that come back at the command and argument outputs;
- the contents of the event mask for each flag combination.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int REG_W   = 32;
  localparam int OPC_W   = 6;
  localparam int FLG_LO  = 6;
  localparam int FLG_W   = 10;
  localparam int B_UPD   = 21;
  localparam int B_START = 31;
  localparam int B_CKEN  = 16;
  localparam int B_CKGATE = 17;

  localparam logic [1:0] A_ARG = 2'd0;
  localparam logic [1:0] A_CMD = 2'd1;
  localparam logic [1:0] A_CLK = 2'd2;
  localparam logic [1:0] A_BUS = 2'd3;

  // index of each flag inside cmd_flags (command bit minus FLG_LO)
  localparam int F_RESP = 0;
  localparam int F_LONG = 1;
  localparam int F_CRC = 2;
  localparam int F_DATA = 3;
  localparam int F_WRITE = 4;
  localparam int F_STREAM = 5;
  localparam int F_ASTOP = 6;
  localparam int F_WAITPRE = 7;
  localparam int F_ABORT = 8;
  localparam int F_INITSEQ = 9;

  typedef struct packed {
    logic             upd;
    logic [FLG_W-1:0] flags;
    logic [OPC_W-1:0] op;
  } cmd_word_t;

  function automatic cmd_word_t f_unpack_cmd(input logic [REG_W-1:0] w);
    cmd_word_t c;
    c.upd   = w[B_UPD];
    c.flags = w[FLG_LO +: FLG_W];
    c.op    = w[OPC_W-1:0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] f_cmd_readback(input logic pend, input cmd_word_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[B_START] = pend;
    r[B_UPD] = c.upd;
    r[FLG_LO +: FLG_W] = c.flags;
    r[OPC_W-1:0] = c.op;
    return r;
  endfunction

  // {auto-stop done, data over, command done}
  function automatic logic [2:0] f_wait_mask(input logic [FLG_W-1:0] fl);
    return {fl[F_DATA] & fl[F_ASTOP], fl[F_DATA], 1'b1};
  endfunction

  function automatic logic f_width_legal(input logic [1:0] code);
    return code != 2'd3;
  endfunction

  function automatic logic [3:0] f_lanes(input logic [1:0] code);
    case (code)
      2'd1:    return 4'b0100;
      2'd2:    return 4'b1000;
      default: return 4'b0001;
    endcase
  endfunction
endpackage

// File: rtl/cfe_cmd_latch.sv
module cfe_cmd_latch
  import cfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic             wr_start,
  input  cmd_word_t        wr_word,
  input  logic [REG_W-1:0] arg_in,
  input  logic             data_busy,
  input  logic             cmd_ready,
  output logic             pending,
  output cmd_word_t        word,
  output logic [REG_W-1:0] arg_q,
  output logic             cmd_valid,
  output logic             clk_apply,
  output logic             launch
);
  logic take_write;
  logic wait_ok;
  logic offered;
  logic accept;

  assign take_write = wr_cmd && !pending;
  assign launch     = take_write && wr_start;
  assign wait_ok    = !(word.flags[F_WAITPRE] && data_busy);
  assign cmd_valid  = pending && !word.upd && (wait_ok || offered);
  assign clk_apply  = pending && word.upd && wait_ok;
  assign accept     = (cmd_valid && cmd_ready) || clk_apply;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      word    <= '0;
      arg_q   <= '0;
      offered <= 1'b0;
    end else begin
      offered <= cmd_valid && !cmd_ready;
      if (take_write) word <= wr_word;
      if (launch) arg_q <= arg_in;
      if (launch) pending <= 1'b1;
      else if (accept) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/cfe_clk_regs.sv
module cfe_clk_regs #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_clk,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_en,
  input  logic             wr_gate,
  input  logic             apply,
  output logic [DIV_W-1:0] cfg_div,
  output logic             cfg_en,
  output logic             cfg_gate,
  output logic [DIV_W-1:0] act_div,
  output logic             act_en,
  output logic             act_gate
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_div  <= '0;
      cfg_en   <= 1'b0;
      cfg_gate <= 1'b0;
      act_div  <= '0;
      act_en   <= 1'b0;
      act_gate <= 1'b0;
    end else begin
      if (wr_clk) begin
        cfg_div  <= wr_div;
        cfg_en   <= wr_en;
        cfg_gate <= wr_gate;
      end
      if (apply) begin
        act_div  <= cfg_div;
        act_en   <= cfg_en;
        act_gate <= cfg_gate;
      end
    end
  end
endmodule

// File: rtl/cfe_clk_gen.sv
module cfe_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             hold,
  input  logic             restart,
  output logic             card_clk,
  output logic             flip
);
  logic [DIV_W-1:0] cnt;
  logic             run;

  assign run  = en && !hold && !restart;
  assign flip = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      card_clk <= 1'b0;
    end else if (!run) begin
      cnt      <= '0;
      card_clk <= 1'b0;
    end else if (flip) begin
      cnt      <= '0;
      card_clk <= !card_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/card_cmd_frontend.sv
module card_cmd_frontend
  import cfe_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [1:0]       reg_raddr,
  output logic [31:0]      reg_rdata,
  input  logic             data_busy,
  input  logic             cmd_ready,
  output logic             cmd_valid,
  output logic [5:0]       cmd_index,
  output logic [9:0]       cmd_flags,
  output logic [31:0]      cmd_arg,
  output logic [2:0]       evt_wait_mask,
  output logic             card_clk,
  output logic [DIV_W-1:0] clk_act_div,
  output logic             clk_act_en,
  output logic [3:0]       bus_lanes
);
  logic             wr_arg, wr_cmd, wr_clk, wr_bus;
  logic [REG_W-1:0] arg_reg;
  logic [1:0]       bw_q;
  cmd_word_t        wr_word, word;
  logic             cmd_pending;
  logic             clk_apply;
  logic             cmd_launch;
  logic             gate_hold;
  logic             clk_flip;
  logic [DIV_W-1:0] cfg_div;
  logic             cfg_en, cfg_gate, act_gate;
  logic [REG_W-1:0] clk_rb;

  assign wr_arg  = reg_we && (reg_addr == A_ARG);
  assign wr_cmd  = reg_we && (reg_addr == A_CMD);
  assign wr_clk  = reg_we && (reg_addr == A_CLK);
  assign wr_bus  = reg_we && (reg_addr == A_BUS);
  assign wr_word = f_unpack_cmd(reg_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_reg <= '0;
      bw_q    <= 2'd0;
    end else begin
      if (wr_arg) arg_reg <= reg_wdata;
      if (wr_bus && f_width_legal(reg_wdata[1:0])) bw_q <= reg_wdata[1:0];
    end
  end

  cfe_cmd_latch u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cmd    (wr_cmd),
    .wr_start  (reg_wdata[B_START]),
    .wr_word   (wr_word),
    .arg_in    (arg_reg),
    .data_busy (data_busy),
    .cmd_ready (cmd_ready),
    .pending   (cmd_pending),
    .word      (word),
    .arg_q     (cmd_arg),
    .cmd_valid (cmd_valid),
    .clk_apply (clk_apply),
    .launch    (cmd_launch)
  );

  cfe_clk_regs #(.DIV_W(DIV_W)) u_ckreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_clk   (wr_clk),
    .wr_div   (reg_wdata[DIV_W-1:0]),
    .wr_en    (reg_wdata[B_CKEN]),
    .wr_gate  (reg_wdata[B_CKGATE]),
    .apply    (clk_apply),
    .cfg_div  (cfg_div),
    .cfg_en   (cfg_en),
    .cfg_gate (cfg_gate),
    .act_div  (clk_act_div),
    .act_en   (clk_act_en),
    .act_gate (act_gate)
  );

  assign gate_hold = act_gate && !cmd_pending && !data_busy;

  cfe_clk_gen #(.DIV_W(DIV_W)) u_ckgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (clk_act_en),
    .div      (clk_act_div),
    .hold     (gate_hold),
    .restart  (clk_apply),
    .card_clk (card_clk),
    .flip     (clk_flip)
  );

  assign cmd_index     = word.op;
  assign cmd_flags     = word.flags;
  assign evt_wait_mask = f_wait_mask(word.flags);
  assign bus_lanes     = f_lanes(bw_q);

  always_comb begin
    clk_rb = '0;
    clk_rb[DIV_W-1:0] = cfg_div;
    clk_rb[B_CKEN] = cfg_en;
    clk_rb[B_CKGATE] = cfg_gate;
  end

  always_comb begin
    case (reg_raddr)
      A_ARG:   reg_rdata = arg_reg;
      A_CMD:   reg_rdata = f_cmd_readback(cmd_pending, word);
      A_CLK:   reg_rdata = clk_rb;
      default: reg_rdata = {30'd0, bw_q};
    endcase
  end
endmodule

// File: rtl/card_cmd_frontend_chk.sv
module card_cmd_frontend_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             data_busy,
  input logic             cmd_ready,
  input logic             cmd_valid,
  input logic [5:0]       cmd_index,
  input logic [9:0]       cmd_flags,
  input logic [31:0]      cmd_arg,
  input logic [2:0]       evt_wait_mask,
  input logic             card_clk,
  input logic [DIV_W-1:0] clk_act_div,
  input logic             clk_act_en,
  input logic [3:0]       bus_lanes,
  input logic             cmd_pending,
  input logic             clk_apply,
  input logic             act_gate
);
  assert_launch_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_pending) |-> $past(reg_we && reg_addr == 2'd1 && reg_wdata[31]));

  assert_valid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index) && $stable(cmd_flags) && $stable(cmd_arg));

  assert_accept_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_pending);

  assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pending && reg_we && reg_addr == 2'd1 |=> $stable(cmd_index) && $stable(cmd_flags));

  assert_wait_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> !(cmd_flags[7] && data_busy));

  assert_wait_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_apply |-> !(cmd_flags[7] && data_busy));

  assert_update_no_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_apply |-> !cmd_valid);

  assert_active_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_apply |=> $stable(clk_act_div) && $stable(clk_act_en) && $stable(act_gate));

  assert_clk_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_act_en |-> !card_clk);

  assert_gate_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_gate && !cmd_pending && !data_busy |=> !card_clk);

  assert_mask_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> evt_wait_mask[0] && (!evt_wait_mask[2] || evt_wait_mask[1]));

  assert_lanes_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bus_lanes) == 1 && !bus_lanes[1]);
endmodule

bind card_cmd_frontend card_cmd_frontend_chk #(.DIV_W(DIV_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .data_busy     (data_busy),
  .cmd_ready     (cmd_ready),
  .cmd_valid     (cmd_valid),
  .cmd_index     (cmd_index),
  .cmd_flags     (cmd_flags),
  .cmd_arg       (cmd_arg),
  .evt_wait_mask (evt_wait_mask),
  .card_clk      (card_clk),
  .clk_act_div   (clk_act_div),
  .clk_act_en    (clk_act_en),
  .bus_lanes     (bus_lanes),
  .cmd_pending   (cmd_pending),
  .clk_apply     (clk_apply),
  .act_gate      (act_gate)
);

// File: tb/sim_card_cmd_frontend.sv
`timescale 1ns/1ps
module sim_card_cmd_frontend;
  localparam logic [31:0] START = 32'h8000_0000;
  localparam logic [31:0] UPD   = 32'h0020_0000;
  localparam logic [31:0] WAITP = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = 2'd0;
  logic [31:0] reg_rdata;
  logic        data_busy = 1'b0;
  logic        cmd_ready = 1'b0;
  logic        cmd_valid;
  logic [5:0]  cmd_index;
  logic [9:0]  cmd_flags;
  logic [31:0] cmd_arg;
  logic [2:0]  evt_wait_mask;
  logic        card_clk;
  logic [7:0]  clk_act_div;
  logic        clk_act_en;
  logic [3:0]  bus_lanes;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic saw_valid = 1'b0;

  always #2 clk = ~clk;

  card_cmd_frontend u0 (.*);

  always @(negedge clk) if (cmd_valid) saw_valid <= 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_raddr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic take();
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic measure(input int exp, input string req);
    logic p;
    int n;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      p = card_clk; @(negedge clk);
      if (!p && card_clk) break;
    end
    for (int i = 0; i < 200; i++) begin
      p = card_clk; @(negedge clk); n++;
      if (!p && card_clk) break;
    end
    chk(req, n, exp);
  endtask

  task automatic count_high(input int cycles, input string req);
    int h;
    h = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (card_clk) h++;
    end
    chk(req, h, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 card_clk", card_clk, 0);
    chk("R1 clk_act_en", clk_act_en, 0);
    chk("R1 bus_lanes", bus_lanes, 4'b0001);
    rd(2'd1, d); chk("R1 cmd readback", d, 0);
  endtask

  task automatic t_launch();
    logic [31:0] d;
    wr(2'd0, 32'h1234_5678);
    wr(2'd1, START | 32'h0000_0151);
    rd(2'd1, d); chk("R2 start reads 1", d[31], 1);
    chk("R2 cmd_valid", cmd_valid, 1);
    chk("R2 index", cmd_index, 17);
    chk("R2 flags", cmd_flags, 10'h005);
    chk("R2 arg", cmd_arg, 32'h1234_5678);
    chk("R10 mask no data", evt_wait_mask, 3'b001);
    wr(2'd0, 32'hDEAD_0000);
    wr(2'd1, START | 32'h0000_0005);
    repeat (2) @(negedge clk);
    chk("R3 valid held", cmd_valid, 1);
    chk("R3 arg held", cmd_arg, 32'h1234_5678);
    chk("R4 index kept", cmd_index, 17);
    take();
    rd(2'd1, d); chk("R3 start cleared", d[31], 0);
    chk("R3 valid dropped", cmd_valid, 0);
  endtask

  task automatic t_masks();
    wr(2'd1, START | 32'h0000_1212);
    chk("R10 data+autostop", evt_wait_mask, 3'b111);
    take();
    wr(2'd1, START | 32'h0000_0213);
    chk("R10 data only", evt_wait_mask, 3'b011);
    take();
    wr(2'd1, START | 32'h0000_1014);
    chk("R10 autostop without data", evt_wait_mask, 3'b001);
    take();
  endtask

  task automatic t_nostart();
    logic [31:0] d;
    wr(2'd1, 32'h0000_0045);
    @(negedge clk);
    chk("R12 no valid", cmd_valid, 0);
    rd(2'd1, d); chk("R12 stored fields", d, 32'h0000_0045);
  endtask

  task automatic t_wait();
    logic [31:0] d;
    data_busy = 1'b1;
    wr(2'd1, START | WAITP | 32'h0000_0018);
    repeat (3) @(negedge clk);
    chk("R5 held while busy", cmd_valid, 0);
    rd(2'd1, d); chk("R5 start still set", d[31], 1);
    data_busy = 1'b0;
    #0.5;
    chk("R5 offered when idle", cmd_valid, 1);
    take();
  endtask

  task automatic t_clock();
    logic [31:0] d;
    wr(2'd2, 32'h0001_0003);
    repeat (4) @(negedge clk);
    chk("R7 active en unchanged", clk_act_en, 0);
    chk("R7 card_clk unchanged", card_clk, 0);
    saw_valid = 1'b0;
    data_busy = 1'b1;
    wr(2'd1, START | UPD | WAITP);
    repeat (3) @(negedge clk);
    chk("R5 update held", clk_act_en, 0);
    data_busy = 1'b0;
    @(negedge clk);
    chk("R6 en applied", clk_act_en, 1);
    chk("R6 div applied", clk_act_div, 3);
    rd(2'd1, d); chk("R6 start cleared", d[31], 0);
    chk("R6 never offered", saw_valid, 0);
    measure(8, "R8 period div3");
    wr(2'd2, 32'h0000_0003);
    wr(2'd1, START | UPD | WAITP);
    @(negedge clk);
    chk("R8 disabled applied", clk_act_en, 0);
    count_high(12, "R8 low when disabled");
    wr(2'd2, 32'h0001_0000);
    wr(2'd1, START | UPD | WAITP);
    measure(2, "R8 period div0");
    wr(2'd2, 32'h0003_0001);
    wr(2'd1, START | UPD | WAITP);
    @(negedge clk);
    count_high(10, "R9 gated low when idle");
    data_busy = 1'b1;
    measure(4, "R9 runs while busy");
    data_busy = 1'b0;
  endtask

  task automatic t_width();
    logic [31:0] d;
    wr(2'd3, 32'd1); chk("R11 code1", bus_lanes, 4'b0100);
    wr(2'd3, 32'd2); chk("R11 code2", bus_lanes, 4'b1000);
    wr(2'd3, 32'd3); chk("R11 code3 ignored", bus_lanes, 4'b1000);
    rd(2'd3, d); chk("R11 readback kept", d, 2);
    wr(2'd3, 32'd0); chk("R11 code0", bus_lanes, 4'b0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_launch();
    t_masks();
    t_nostart();
    t_wait();
    t_clock();
    t_width();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule